// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Peak Hold

This block is the digital half of a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC and reads one greater-than bit back from an external clocked comparator. It then settles the code one bit per cycle, from the most significant bit down to the least significant bit. The finished code is published on a result register with a one-cycle done strobe. A second register holds the largest result produced since reset.

The sequencer advances on its own SAR clock phase. The comparator decision is latched on the falling edge of a separate evaluation phase, so a comparator output sitting near mid-rail is never seen by the sequencing logic. For production test, a test-mode pin joins every sequencing flip-flop into a single shift chain that runs from a serial input to a serial output.

Top module: `sar_peak_ctrl`

## Requirements
- R1: A synchronous reset sets `dac_code`, `result` and `peak` to zero, drives `done` low and leaves the sequencer idle.
- R2: When `start` is high at a clock edge while the sequencer is idle and `test_mode` is low, the next `dac_code` is the trial code with only bit N-1 set.
- R3: At each step the bit under test stays 1 when the latched comparator bit is 1 (input at or above the DAC output) and is cleared when it is 0. At the same edge the next lower bit is set to 1. With an ideal comparator the final code equals the input code.
- R4: `done` is high for exactly one cycle. It rises N clock edges after the edge that accepted `start`.
- R5: `result` changes only on the cycle in which `done` is high, or through scan shifting.
- R6: When `done` is high, `peak` equals the larger of its previous value and the new `result`.
- R7: A `start` pulse that arrives while a conversion is in progress is ignored. The running conversion keeps its latency and its result.
- R8: The comparator bit is latched on the falling edge of `eval_ph`. A change on `cmp_gt` after that edge and before the next clock edge has no effect on the decision.
- R9: While `test_mode` is high, every sequencing register shifts by one position per clock edge. `scan_in` enters bit 0 of `peak`, and `scan_out` presents the head of the chain. Reading from the head toward `scan_in`, the order is: the state bit (1 means converting), the bit-index counter (MSB first), the done flop, the trial code, `result`, and `peak`, each MSB first.
- R10: A value shifted in through the chain becomes the live state once `test_mode` returns low. A loaded `peak` is kept when later results are smaller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SAR sequencing clock phase |
| rst | input | 1 | Synchronous reset, active high |
| eval_ph | input | 1 | Comparator evaluation phase; its falling edge latches `cmp_gt` |
| start | input | 1 | Request to begin a conversion |
| cmp_gt | input | 1 | Comparator output, 1 when the input is at or above the DAC output |
| test_mode | input | 1 | Selects scan shifting in place of normal operation |
| scan_in | input | 1 | Serial input to the scan chain |
| dac_code | output | N | Trial code driven to the DAC |
| done | output | 1 | One-cycle strobe marking a finished conversion |
| result | output | N | Last finished conversion |
| peak | output | N | Largest result since reset |
| scan_out | output | 1 | Head of the scan chain |

## Verification
The bench builds the block at its default width N = 8. At this width the boundary codes 0x00 and 0xFF, the single-bit codes and the alternating patterns can all be swept through the comparator model in one short table. The 29-bit scan chain is also short enough to unload and reload in full and to compare bit by bit. An 8-step conversion leaves room to inject a stray start pulse, a late comparator glitch and a mid-conversion reset at known step positions.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;

endpackage

// File: rtl/sar_gt_capture.sv
module sar_gt_capture (
  input  logic eval_ph,
  input  logic cmp_gt,
  output logic gt_q
);

  // decision latched at the end of evaluation, isolating mid-rail levels
  always_ff @(negedge eval_ph) begin
    gt_q <= cmp_gt;
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic         scan_in,
  input  logic         start,
  input  logic         gt_q,
  output logic         scan_out,
  output logic [N-1:0] trial,
  output logic         busy,
  output logic         done,
  output logic         fin_stb,
  output logic [N-1:0] fin_code
);

  localparam int SW = 2 + IW + N;
  localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);
  localparam logic [N-1:0]  MSB_ONE = N'(1) << (N - 1);

  sar_state_e     state_q;
  logic [IW-1:0]  idx_q;
  logic           done_q;
  logic [N-1:0]   trial_q;
  logic [SW-1:0]  chain_cur;
  logic [SW-1:0]  chain_shf;
  logic           last_step;

  // decide bit pos from the comparator and arm the bit below it
  function automatic logic [N-1:0] step_code(input logic [N-1:0]  code,
                                             input logic [IW-1:0] pos,
                                             input logic          keep);
    logic [N-1:0] c;
    c      = code;
    c[pos] = keep;
    if (pos != '0) c[pos - 1'b1] = 1'b1;
    return c;
  endfunction

  assign chain_cur = {state_q, idx_q, done_q, trial_q};
  assign chain_shf = {chain_cur[SW-2:0], scan_in};
  assign last_step = (state_q == ST_CONV) && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      trial_q <= '0;
    end else if (test_mode) begin
      state_q <= sar_state_e'(chain_shf[SW-1]);
      idx_q   <= chain_shf[SW-2 -: IW];
      done_q  <= chain_shf[N];
      trial_q <= chain_shf[N-1:0];
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            trial_q <= MSB_ONE;
            idx_q   <= TOP_IDX;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          trial_q <= step_code(trial_q, idx_q, gt_q);
          if (idx_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_out = chain_cur[SW-1];
  assign trial    = trial_q;
  assign busy     = (state_q == ST_CONV);
  assign done     = done_q;
  assign fin_stb  = last_step && !test_mode;
  assign fin_code = step_code(trial_q, idx_q, gt_q);

endmodule

// File: rtl/sar_hold.sv
module sar_hold #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic         scan_in,
  input  logic         fin_stb,
  input  logic [N-1:0] fin_code,
  output logic         scan_out,
  output logic [N-1:0] result,
  output logic [N-1:0] peak
);

  localparam int HW = 2 * N;

  logic [N-1:0]  result_q;
  logic [N-1:0]  peak_q;
  logic [HW-1:0] seg_cur;
  logic [HW-1:0] seg_shf;

  function automatic logic [N-1:0] larger(input logic [N-1:0] a,
                                          input logic [N-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign seg_cur = {result_q, peak_q};
  assign seg_shf = {seg_cur[HW-2:0], scan_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      peak_q   <= '0;
    end else if (test_mode) begin
      result_q <= seg_shf[HW-1:N];
      peak_q   <= seg_shf[N-1:0];
    end else if (fin_stb) begin
      result_q <= fin_code;
      peak_q   <= larger(peak_q, fin_code);
    end
  end

  assign scan_out = seg_cur[HW-1];
  assign result   = result_q;
  assign peak     = peak_q;

endmodule

// File: rtl/sar_peak_ctrl.sv
module sar_peak_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         eval_ph,
  input  logic         start,
  input  logic         cmp_gt,
  input  logic         test_mode,
  input  logic         scan_in,
  output logic [N-1:0] dac_code,
  output logic         done,
  output logic [N-1:0] result,
  output logic [N-1:0] peak,
  output logic         scan_out
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic         gt_q;
  logic         busy;
  logic         fin_stb;
  logic [N-1:0] fin_code;
  logic         hold_so;

  sar_gt_capture u_cap (
    .eval_ph (eval_ph),
    .cmp_gt  (cmp_gt),
    .gt_q    (gt_q)
  );

  sar_hold #(.N(N)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .fin_stb   (fin_stb),
    .fin_code  (fin_code),
    .scan_out  (hold_so),
    .result    (result),
    .peak      (peak)
  );

  sar_seq #(.N(N), .IW(IW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .scan_in   (hold_so),
    .start     (start),
    .gt_q      (gt_q),
    .scan_out  (scan_out),
    .trial     (dac_code),
    .busy      (busy),
    .done      (done),
    .fin_stb   (fin_stb),
    .fin_code  (fin_code)
  );

endmodule

// File: rtl/sar_peak_ctrl_chk.sv
module sar_peak_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         test_mode,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         scan_in,
  input logic [N-1:0] dac_code,
  input logic [N-1:0] result,
  input logic [N-1:0] peak
);

  localparam logic [N-1:0] MSB_ONE = N'(1) << (N - 1);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_code == '0 && result == '0 && peak == '0 && !done));

  p_start_loads_msb_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !test_mode) |=> (busy && dac_code == MSB_ONE));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !test_mode) |=> !done);

  p_result_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(test_mode) && !$past(rst)) |-> $stable(result));

  p_peak_is_max_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(test_mode) && !$past(rst)) |->
      (peak == ((result > $past(peak)) ? result : $past(peak))));

  p_scan_shift_r9: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> (peak[0] == $past(scan_in) && result[0] == $past(peak[N-1])));

endmodule

bind sar_peak_ctrl sar_peak_ctrl_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .test_mode (test_mode),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .scan_in   (scan_in),
  .dac_code  (dac_code),
  .result    (result),
  .peak      (peak)
);

// File: tb/sar_peak_ctrl_tb.sv
module sar_peak_ctrl_tb;

  localparam int N      = 8;
  localparam int IW     = $clog2(N);
  localparam int W      = 2 + IW + 3 * N;
  localparam int CLK_PERIOD = 10;
  localparam int NV     = 8;
  // each entry: {input code, expected result}
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'hFFFF, 16'h8080, 16'h7F7F,
    16'h5555, 16'hAAAA, 16'h0101, 16'hC3C3
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         eval_ph = 1'b0;
  logic         start = 1'b0;
  logic         cmp_gt = 1'b0;
  logic         test_mode = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] dac_code;
  logic         done;
  logic [N-1:0] result;
  logic [N-1:0] peak;
  logic         scan_out;

  logic [N-1:0] vin = '0;
  logic         corrupt = 1'b0;
  int           n_chk = 0;
  int           n_fail = 0;

  sar_peak_ctrl #(.N(N)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .eval_ph   (eval_ph),
    .start     (start),
    .cmp_gt    (cmp_gt),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .dac_code  (dac_code),
    .done      (done),
    .result    (result),
    .peak      (peak),
    .scan_out  (scan_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // evaluation phase sits inside the cycle, after the trial code settles
  always begin
    @(posedge clk);
    #2 eval_ph = 1'b1;
    #4 eval_ph = 1'b0;
  end

  // ideal comparator: 1 when the input is at or above the DAC output
  always @(posedge eval_ph) cmp_gt = (vin >= dac_code);
  always @(negedge eval_ph) if (corrupt) #1 cmp_gt = ~cmp_gt;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // runs one conversion; returns edges from accept to done and first trial code
  task automatic convert(input logic [N-1:0] v, input bit stray_start,
                         output int cyc, output logic [N-1:0] first_dac);
    vin = v;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    first_dac = dac_code;
    cyc = 0;
    while (!done && cyc < 4 * N) begin
      cyc++;
      if (stray_start && cyc == 3) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int           cyc;
    logic [N-1:0] fd;
    logic [N-1:0] pk;
    logic [N-1:0] last;
    logic [W-1:0] exp_chain;
    logic [W-1:0] got_chain;
    logic [W-1:0] load_chain;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dac_code == '0 && result == '0 && peak == '0 && !done, "R1 reset",
        {dac_code, result, peak, 7'b0, done}, 32'h0);
    rst = 1'b0;

    pk = '0;
    last = '0;
    for (int i = 0; i < NV; i++) begin
      convert(VEC[i][15:8], 1'b0, cyc, fd);
      pk = (VEC[i][7:0] > pk) ? VEC[i][7:0] : pk;
      last = VEC[i][7:0];
      chk(fd == 8'h80, "R2 first trial", fd, 8'h80);
      chk(cyc == N, "R4 latency", cyc, N);
      chk(result == VEC[i][7:0], "R3 result", result, VEC[i][7:0]);
      chk(peak == pk, "R6 peak", peak, pk);
      @(negedge clk);
      chk(!done && result == VEC[i][7:0], "R4 R5 done one cycle, result held",
          {done, result}, {1'b0, VEC[i][7:0]});
    end

    // R9: unload the chain and load a new image
    exp_chain  = {1'b0, IW'(0), 1'b0, last, last, pk};
    load_chain = {1'b0, IW'(0), 1'b0, 8'h00, 8'h00, 8'hF0};
    for (int i = 0; i < W; i++) begin
      got_chain[W-1-i] = scan_out;
      scan_in   = load_chain[W-1-i];
      test_mode = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    test_mode = 1'b0;
    scan_in   = 1'b0;
    chk(got_chain == exp_chain, "R9 chain order", got_chain, exp_chain);
    // R10: loaded image is live
    chk(peak == 8'hF0 && result == 8'h00 && dac_code == 8'h00 && !done,
        "R10 loaded state", {dac_code, result, peak}, {8'h00, 8'h00, 8'hF0});
    convert(8'h30, 1'b0, cyc, fd);
    chk(result == 8'h30 && peak == 8'hF0, "R10 loaded peak kept",
        {result, peak}, {8'h30, 8'hF0});
    convert(8'hF5, 1'b0, cyc, fd);
    chk(peak == 8'hF5, "R6 peak raised after load", peak, 8'hF5);

    // R7: stray start mid-conversion
    convert(8'h4B, 1'b1, cyc, fd);
    chk(cyc == N && result == 8'h4B, "R7 stray start ignored",
        {cyc[7:0], result}, {8'(N), 8'h4B});
    @(negedge clk);
    chk(dac_code == 8'h4B && !done, "R7 no second conversion",
        {done, dac_code}, {1'b0, 8'h4B});

    // R8: comparator flips after the latch edge
    corrupt = 1'b1;
    convert(8'h5A, 1'b0, cyc, fd);
    corrupt = 1'b0;
    chk(result == 8'h5A, "R8 late glitch ignored", result, 8'h5A);

    // R1: reset in the middle of a conversion
    vin = 8'h99;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(dac_code == '0 && result == '0 && peak == '0 && !done,
        "R1 mid-conversion reset", {dac_code, result, peak}, 24'h0);
    rst = 1'b0;
    repeat (N + 2) @(negedge clk);
    chk(!done && dac_code == '0, "R1 idle after reset", {done, dac_code}, 9'h0);

    finish_run();
  end

endmodule